// File: doc/BRIEF.md
# Selectable Static Branch Direction Predictor

This block guesses, in the fetch stage, whether a conditional branch will be taken, and gives fetch the address to read next. The guess follows a static policy picked at run time by a two-bit mode input: every branch taken, every branch not taken, or a direction rule in which a branch pointing back to a lower or equal address is guessed taken and one pointing forward is guessed not taken. The fetch-side outputs are combinational, so the guess and the next address are ready in the cycle in which the branch is presented.

The guess travels down the pipeline with the branch. When the branch resolves, the resolving stage hands back the branch address, its resolved target and the guess it carried. The block works out the true direction from the resolved target. In the following cycle it raises a one-cycle misprediction flag together with the fixed number of bubble cycles that the flush costs. Addresses count instruction words, so the sequential successor of an address is that address plus one.

Top module: `branch_dir_predictor`

## Requirements
- R1: With mode 2'b00, every valid branch is predicted not taken.
- R2: With mode 2'b01, every valid branch is predicted taken.
- R3: With mode 2'b10, a valid branch is predicted not taken when its target is strictly greater than its PC as an unsigned number, and taken when the target is less than or equal to the PC.
- R4: With mode 2'b11, every valid branch is predicted taken.
- R5: The predicted next PC equals the target when the prediction is taken, and PC + 1 (modulo 2^ADDR_W) when it is not. The output uses the same cycle as the fetch inputs.
- R6: A resolved branch counts as actually taken exactly when its resolved target differs from its PC + 1 (modulo 2^ADDR_W).
- R7: One cycle after a resolve strobe for a branch whose actual direction differs from the carried prediction, the mispredict flag is 1 and the penalty output is 3. In every other cycle the flag is 0 and the penalty is 0, so the flag lasts one cycle per strobe.
- R8: A fetch slot that is not valid, or is not a branch, gives a not-taken prediction. A resolve strobe for a non-branch never raises the mispredict flag.
- R9: While reset is held, the mispredict flag and the penalty are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy select: 00 not taken, 01 taken, 10 backward taken / forward not taken, 11 taken |
| f_valid | input | 1 | Fetch slot holds a valid instruction |
| f_is_branch | input | 1 | Fetch slot instruction is a conditional branch |
| f_pc | input | ADDR_W | Word address of the fetched instruction |
| f_target | input | ADDR_W | Decoded branch target |
| pred_taken | output | 1 | Predicted direction |
| pred_next_pc | output | ADDR_W | Address to fetch next |
| r_valid | input | 1 | Resolve strobe |
| r_is_branch | input | 1 | Resolving instruction is a branch |
| r_pc | input | ADDR_W | Word address of the resolving instruction |
| r_target | input | ADDR_W | Resolved next address of the branch |
| r_pred_taken | input | 1 | Prediction that travelled with the branch |
| mispredict | output | 1 | Registered misprediction flag |
| penalty | output | PEN_W | Registered bubble count, 3 on a misprediction |

## Verification
The direction rule hinges on the case where target equals PC. A design that used a less-than-or-equal test for forward branches would guess a self-loop not taken. The address sweep covers every PC and target pair, so this case and the wrap at the top of the address space are both hit. A design that compared the resolved target with the PC rather than with PC + 1 would flag a fall-through branch as taken. Other faults the bench goes after: a flag that stays up for more than one cycle, a penalty that does not drop to zero, and a non-branch resolve that raises the flag.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    POL_NEVER    = 2'b00,
    POL_ALWAYS   = 2'b01,
    POL_BACKWARD = 2'b10,
    POL_FALLBACK = 2'b11
  } bp_policy_e;
endpackage

// File: rtl/bp_direction.sv
module bp_direction
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        mode,
  input  logic              slot_branch,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  output logic              taken
);
  logic forward;
  logic policy_taken;

  assign forward = (target > pc);

  always_comb begin
    case (bp_policy_e'(mode))
      POL_NEVER:    policy_taken = 1'b0;
      POL_ALWAYS:   policy_taken = 1'b1;
      POL_BACKWARD: policy_taken = ~forward;
      default:      policy_taken = 1'b1;
    endcase
  end

  assign taken = slot_branch & policy_taken;
endmodule

// File: rtl/bp_next_pc.sv
module bp_next_pc #(
  parameter int ADDR_W = 32
) (
  input  logic              taken,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_pc
);
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc  = pc + ADDR_W'(1);
  assign next_pc = taken ? target : seq_pc;
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int ADDR_W  = 32,
  parameter int PENALTY = 3,
  parameter int PEN_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              r_valid,
  input  logic              r_is_branch,
  input  logic [ADDR_W-1:0] r_pc,
  input  logic [ADDR_W-1:0] r_target,
  input  logic              r_pred_taken,
  output logic              mispredict,
  output logic [PEN_W-1:0]  penalty
);
  localparam logic [PEN_W-1:0] PEN_VAL = PEN_W'(PENALTY);

  logic              actual_taken;
  logic              miss_d, miss_q;
  logic [PEN_W-1:0]  pen_d, pen_q;
  logic              upd_en;

  always_comb begin
    actual_taken = (r_target != (r_pc + ADDR_W'(1)));
    miss_d       = r_valid & r_is_branch & (actual_taken ^ r_pred_taken);
    pen_d        = miss_d ? PEN_VAL : '0;
    upd_en       = r_valid | miss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= 1'b0;
      pen_q  <= '0;
    end else if (upd_en) begin
      miss_q <= miss_d;
      pen_q  <= pen_d;
    end
  end

  assign mispredict = miss_q;
  assign penalty    = pen_q;
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
  parameter int ADDR_W  = 32,
  parameter int PENALTY = 3,
  parameter int PEN_W   = $clog2(PENALTY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              f_valid,
  input  logic              f_is_branch,
  input  logic [ADDR_W-1:0] f_pc,
  input  logic [ADDR_W-1:0] f_target,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              r_valid,
  input  logic              r_is_branch,
  input  logic [ADDR_W-1:0] r_pc,
  input  logic [ADDR_W-1:0] r_target,
  input  logic              r_pred_taken,
  output logic              mispredict,
  output logic [PEN_W-1:0]  penalty
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic slot_branch;
  assign slot_branch = f_valid & f_is_branch;

  bp_direction #(.ADDR_W(ADDR_W)) u_dir (
    .mode        (mode),
    .slot_branch (slot_branch),
    .pc          (f_pc),
    .target      (f_target),
    .taken       (pred_taken)
  );

  bp_next_pc #(.ADDR_W(ADDR_W)) u_npc (
    .taken   (pred_taken),
    .pc      (f_pc),
    .target  (f_target),
    .next_pc (pred_next_pc)
  );

  bp_resolve #(.ADDR_W(ADDR_W), .PENALTY(PENALTY), .PEN_W(PEN_W)) u_res (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .r_valid      (r_valid),
    .r_is_branch  (r_is_branch),
    .r_pc         (r_pc),
    .r_target     (r_target),
    .r_pred_taken (r_pred_taken),
    .mispredict   (mispredict),
    .penalty      (penalty)
  );
endmodule

// File: rtl/branch_dir_predictor_chk.sv
module branch_dir_predictor_chk #(
  parameter int ADDR_W  = 32,
  parameter int PENALTY = 3,
  parameter int PEN_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              f_valid,
  input logic              f_is_branch,
  input logic [ADDR_W-1:0] f_pc,
  input logic [ADDR_W-1:0] f_target,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              r_valid,
  input logic              r_is_branch,
  input logic [ADDR_W-1:0] r_pc,
  input logic [ADDR_W-1:0] r_target,
  input logic              r_pred_taken,
  input logic              mispredict,
  input logic [PEN_W-1:0]  penalty
);
  AST_NEVER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && f_is_branch && mode == 2'b00) |-> !pred_taken); // R1
  AST_ALWAYS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && f_is_branch && mode == 2'b01) |-> pred_taken); // R2
  AST_BACKWARD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && f_is_branch && mode == 2'b10 && f_target <= f_pc) |-> pred_taken); // R3
  AST_FALLBACK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && f_is_branch && mode == 2'b11) |-> pred_taken); // R4
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> (pred_next_pc == f_target)); // R5
  AST_MISS_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> (penalty == PEN_W'(PENALTY))); // R7
  AST_QUIET_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    !mispredict |-> (penalty == '0)); // R7
  AST_NONBRANCH_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_valid && r_is_branch) |=> !mispredict); // R8
  AST_NONBRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_valid && f_is_branch) |-> !pred_taken); // R8
endmodule

bind branch_dir_predictor branch_dir_predictor_chk #(
  .ADDR_W(ADDR_W), .PENALTY(PENALTY), .PEN_W(PEN_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .mode         (mode),
  .f_valid      (f_valid),
  .f_is_branch  (f_is_branch),
  .f_pc         (f_pc),
  .f_target     (f_target),
  .pred_taken   (pred_taken),
  .pred_next_pc (pred_next_pc),
  .r_valid      (r_valid),
  .r_is_branch  (r_is_branch),
  .r_pc         (r_pc),
  .r_target     (r_target),
  .r_pred_taken (r_pred_taken),
  .mispredict   (mispredict),
  .penalty      (penalty)
);

// File: tb/branch_dir_predictor_tb.sv
`timescale 1ns/1ps
module branch_dir_predictor_tb;
  localparam int AW = 5;
  localparam int PW = 2;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          f_valid, f_is_branch;
  logic [AW-1:0] f_pc, f_target;
  logic          pred_taken;
  logic [AW-1:0] pred_next_pc;
  logic          r_valid, r_is_branch, r_pred_taken;
  logic [AW-1:0] r_pc, r_target;
  logic          mispredict;
  logic [PW-1:0] penalty;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  branch_dir_predictor #(.ADDR_W(AW), .PENALTY(3), .PEN_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .f_valid(f_valid), .f_is_branch(f_is_branch), .f_pc(f_pc), .f_target(f_target),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .r_valid(r_valid), .r_is_branch(r_is_branch), .r_pc(r_pc), .r_target(r_target),
    .r_pred_taken(r_pred_taken), .mispredict(mispredict), .penalty(penalty)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_dir(int m, int pc, int tgt, int br);
    if (!br) return 0;
    case (m)
      0: return 0;
      1: return 1;
      2: return (tgt > pc) ? 0 : 1;
      default: return 1;
    endcase
  endfunction

  task automatic resolve(input int v, input int br, input int pc, input int tgt,
                         input int pr, input string req);
    int act_taken, exp_miss;
    r_valid = v[0]; r_is_branch = br[0];
    r_pc = AW'(pc); r_target = AW'(tgt); r_pred_taken = pr[0];
    act_taken = (tgt != ((pc + 1) % N)) ? 1 : 0;
    exp_miss  = (v != 0 && br != 0 && act_taken != pr) ? 1 : 0;
    @(negedge clk);
    check(req, int'(mispredict), exp_miss);
    check(req, int'(penalty), exp_miss ? 3 : 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; f_valid = 0; f_is_branch = 0; f_pc = '0; f_target = '0;
    r_valid = 1; r_is_branch = 1; r_pc = 5'd3; r_target = 5'd9; r_pred_taken = 0;
    repeat (3) @(negedge clk);
    check("R9", int'(mispredict), 0);   // R9 mismatch driven during reset
    check("R9", int'(penalty), 0);
    r_valid = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", int'(mispredict), 0);

    // Fetch sweep: R1 R2 R3 R4 R5 R8
    for (int m = 0; m < 4; m++)
      for (int sel = 0; sel < 4; sel++)
        for (int pc = 0; pc < N; pc++)
          for (int tgt = 0; tgt < N; tgt++) begin
            int e, en;
            string req;
            mode = 2'(m); f_valid = sel[0]; f_is_branch = sel[1];
            f_pc = AW'(pc); f_target = AW'(tgt);
            #0.5;
            e  = exp_dir(m, pc, tgt, (sel == 3) ? 1 : 0);
            en = e ? tgt : (pc + 1) % N;
            req = (sel != 3) ? "R8" : (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
            check(req, int'(pred_taken), e);
            check("R5", int'(pred_next_pc), en);
          end

    // Resolve sweep: R6 R7
    @(negedge clk);
    for (int pc = 0; pc < N; pc++)
      for (int tgt = 0; tgt < N; tgt++)
        for (int pr = 0; pr < 2; pr++)
          resolve(1, 1, pc, tgt, pr, "R6_R7");

    // one-cycle flag: mispredict then idle
    resolve(1, 1, 4, 20, 0, "R7");
    resolve(0, 1, 4, 20, 0, "R7");
    // wrap: pc at top, target 0 is fall-through, predicted taken -> miss
    resolve(1, 1, N - 1, 0, 1, "R6");
    resolve(1, 1, N - 1, 0, 0, "R6");
    // non-branch resolve with mismatching outcome
    resolve(1, 0, 2, 17, 0, "R8");
    resolve(1, 0, 2, 3, 1, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule